// File: doc/BRIEF.md
# Power-Fail Memory Access Guard

This block sits between a memory controller and an external battery-backed asynchronous SRAM. It passes the controller's chip-enable, write-enable and output-enable requests on to the memory's active-low strobes. It blocks all of them whenever the supply-status inputs report a power problem. Two digital flags arrive from off-block comparators. `pfail_i` means the supply is below the fail threshold, nominally between 2.8 V and 3.0 V. `swover_i` means the supply is below the battery switch point, near 2.5 V. Each flag passes through a multi-flop synchronizer.

The fail flag is also glitch-filtered. It must stay high for a programmable number of cycles before protection is declared. The switchover flag trips protection as soon as it has been synchronized. Once tripped, the guard holds the memory deselected, so the SRAM's data pins go high-impedance and no write can land. If an access is in flight when the trip occurs, write-enable drops in the same cycle and the controller receives a one-cycle abort pulse.

When both flags clear, the guard waits out a chip-enable recovery interval before it lets accesses resume. The default is 80 ms at 50 MHz, and any legal value lies between 40 ms and 120 ms. The guard has three states: NORMAL, PROTECTED and RECOVERING. It reports `ready_o` and `protected_o` to the controller.

Top module: `pwr_guard`

## Requirements
- R1: After reset the guard is in PROTECTED: `ready_o`=0, `protected_o`=1, and `mem_ce_no`, `mem_we_no` and `mem_oe_no` are all 1, whatever the requests are.
- R2: While the filtered fail flag or the synchronized switchover flag is high, `mem_we_no` is 1, and a write request has no effect on it.
- R3: Outside NORMAL, or while a trip is present, `mem_ce_no` and `mem_oe_no` are 1, so the memory outputs stay high-impedance.
- R4: `pfail_i` trips protection only after its synchronized value has been high for FILT_CYC consecutive cycles. A shorter pulse leaves `ready_o` and `protected_o` unchanged.
- R5: When `pfail_i` is held high, `protected_o` is 1 no later than SYNC_STAGES+FILT_CYC cycles after the first edge that samples it. This bound lies far inside the 250 µs write-protect limit.
- R6: Once both flags have cleared, RECOVERING lasts exactly REC_CYC = (CLK_HZ/1e6)·RECOVER_US cycles and then NORMAL is entered. `protected_o` is 0 and `ready_o` is 0 during RECOVERING.
- R7: A trip during RECOVERING returns the guard to PROTECTED. The next recovery then counts the full REC_CYC cycles from zero.
- R8: `ready_o` is 1 only in NORMAL with no trip. In that case `mem_ce_no` = !ce_req, `mem_we_no` = !(ce_req & we_req) and `mem_oe_no` = !(ce_req & oe_req).
- R9: `abort_o` pulses for exactly one cycle when a trip is first seen in NORMAL while `ce_req_i` is 1. It stays 0 when no access is requested.
- R10: `swover_i` bypasses the glitch filter: `protected_o` rises SYNC_STAGES cycles after the edge that first samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pfail_i | input | 1 | Supply below fail threshold (asynchronous) |
| swover_i | input | 1 | Supply below battery switch point (asynchronous) |
| ce_req_i | input | 1 | Controller chip-select request, active high |
| we_req_i | input | 1 | Controller write request, active high |
| oe_req_i | input | 1 | Controller read-drive request, active high |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| ready_o | output | 1 | Accesses allowed |
| protected_o | output | 1 | Write protection in force |
| abort_o | output | 1 | One-cycle pulse: in-flight access cut off |

## Verification
The assertions check the following on every cycle:
- write-enable stays blocked under any trip;
- all strobes stay idle outside NORMAL;
- the fail-to-protection latency is bounded, measured by a counter on the raw flag;
- NORMAL is entered only from RECOVERING;
- a trip during recovery leaves RECOVERING;
- the abort pulse lasts a single cycle.

Only the bench's scenarios show the other properties:
- the exact recovery length;
- the full restart of recovery after a re-trip;
- a sub-threshold glitch being ignored;
- the switchover bypass latency.

The bench's reference model compares every output on every cycle as well.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL     = 2'd0,
    ST_PROTECTED  = 2'd1,
    ST_RECOVERING = 2'd2
  } guard_state_e;
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) stg_q[i] <= stg_q[i-1];
      stg_q[0] <= d_i;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pg_filter.sv
module pg_filter #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic fail_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!in_i)              cnt_q <= '0;
    else if (cnt_q != CW'(HOLD)) cnt_q <= cnt_q + 1'b1;
  end

  assign fail_o = (cnt_q == CW'(HOLD));

  AST_FILT_NEEDS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> $past(in_i)); // R4
endmodule

// File: rtl/pg_fsm.sv
module pg_fsm
  import pwr_guard_pkg::*;
#(
  parameter int unsigned REC_CYC = 4_000_000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         trip_i,
  output guard_state_e state_o
);
  localparam int unsigned TW   = (REC_CYC > 1) ? $clog2(REC_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(REC_CYC - 1);

  guard_state_e state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    unique case (state_q)
      ST_NORMAL: begin
        tmr_d = '0;
        if (trip_i) state_d = ST_PROTECTED;
      end
      ST_PROTECTED: begin
        tmr_d = '0;
        if (!trip_i) state_d = ST_RECOVERING;
      end
      ST_RECOVERING: begin
        if (trip_i) begin
          state_d = ST_PROTECTED;
          tmr_d   = '0;
        end else if (tmr_q == LAST) begin
          state_d = ST_NORMAL;
          tmr_d   = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_PROTECTED;
        tmr_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PROTECTED;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  assign state_o = state_q;

  AST_NORMAL_FROM_REC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NORMAL && $past(state_q) != ST_NORMAL) |-> $past(state_q) == ST_RECOVERING); // R6
  AST_TRIP_LEAVES_REC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOVERING && trip_i) |=> state_q == ST_PROTECTED); // R7
endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
  import pwr_guard_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned RECOVER_US  = 80_000,
  parameter int unsigned FILT_CYC    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pfail_i,
  input  logic swover_i,
  input  logic ce_req_i,
  input  logic we_req_i,
  input  logic oe_req_i,
  output logic mem_ce_no,
  output logic mem_we_no,
  output logic mem_oe_no,
  output logic ready_o,
  output logic protected_o,
  output logic abort_o
);
  localparam int unsigned REC_CYC = (CLK_HZ / 1_000_000) * RECOVER_US;
  localparam int unsigned LAT     = SYNC_STAGES + FILT_CYC;
  localparam int unsigned LW      = $clog2(LAT + 1);

  logic [1:0]   flags_s;
  logic         pf_s, sw_s, pf_filt, trip, allow;
  guard_state_e gst;

  pg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({swover_i, pfail_i}),
    .q_o   (flags_s)
  );

  assign pf_s = flags_s[0];
  assign sw_s = flags_s[1];

  pg_filter #(.HOLD(FILT_CYC)) u_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (pf_s),
    .fail_o(pf_filt)
  );

  // switchover is a deeper fault: no filtering
  assign trip = pf_filt | sw_s;

  pg_fsm #(.REC_CYC(REC_CYC)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trip_i (trip),
    .state_o(gst)
  );

  // gate in the trip cycle itself, ahead of the state register
  assign allow       = (gst == ST_NORMAL) & ~trip;
  assign mem_ce_no   = ~(ce_req_i & allow);
  assign mem_we_no   = ~(ce_req_i & we_req_i & allow);
  assign mem_oe_no   = ~(ce_req_i & oe_req_i & allow);
  assign ready_o     = allow;
  assign protected_o = trip | (gst == ST_PROTECTED);
  assign abort_o     = (gst == ST_NORMAL) & trip & ce_req_i;

  // raw-flag run length, used only to bound protection latency
  logic [LW-1:0] raw_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    raw_run_q <= '0;
    else if (!pfail_i)              raw_run_q <= '0;
    else if (raw_run_q != LW'(LAT)) raw_run_q <= raw_run_q + 1'b1;
  end

  AST_WE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip |-> mem_we_no); // R2
  AST_STROBES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gst != ST_NORMAL) |-> (mem_ce_no && mem_oe_no && mem_we_no)); // R3
  AST_WP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_run_q == LW'(LAT)) |-> protected_o); // R5
  AST_READY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!protected_o && gst == ST_NORMAL)); // R8
  AST_ABORT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o); // R9
  AST_SW_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_s |-> (protected_o && !ready_o)); // R10
endmodule

// File: tb/pwr_guard_bench.sv
`timescale 1ns/1ps
module pwr_guard_bench;
  localparam int unsigned CLK_HZ  = 1_000_000;
  localparam int unsigned REC_US  = 20;
  localparam int unsigned FILT    = 3;
  localparam int unsigned STAGES  = 2;
  localparam int          REC_CYC = (CLK_HZ / 1_000_000) * REC_US;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pfail = 1'b0, swover = 1'b0, ce_req = 1'b0, we_req = 1'b0, oe_req = 1'b0;
  logic mem_ce_n, mem_we_n, mem_oe_n, ready, prot, abort_p;

  int n_cmp = 0, n_err = 0;

  always #2 clk = ~clk;

  pwr_guard #(.CLK_HZ(CLK_HZ), .RECOVER_US(REC_US), .FILT_CYC(FILT), .SYNC_STAGES(STAGES)) u_pwr_guard (
    .clk_i(clk), .rst_ni(rst_n), .pfail_i(pfail), .swover_i(swover),
    .ce_req_i(ce_req), .we_req_i(we_req), .oe_req_i(oe_req),
    .mem_ce_no(mem_ce_n), .mem_we_no(mem_we_n), .mem_oe_no(mem_oe_n),
    .ready_o(ready), .protected_o(prot), .abort_o(abort_p)
  );

  // behavioural reference: 0 normal, 1 protected, 2 recovering
  bit pf_q[$], sw_q[$];
  int m_st, m_cnt, m_tmr;

  function automatic bit m_trip();
    return (m_cnt >= FILT) || sw_q[0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q.delete(); sw_q.delete();
      for (int i = 0; i < STAGES; i++) begin pf_q.push_back(1'b0); sw_q.push_back(1'b0); end
      m_st = 1; m_cnt = 0; m_tmr = 0;
    end else begin
      bit t;
      t = m_trip();
      case (m_st)
        0: if (t) m_st = 1;
        1: if (!t) begin m_st = 2; m_tmr = 0; end
        default: begin
          if (t) m_st = 1;
          else if (m_tmr == REC_CYC - 1) m_st = 0;
          else m_tmr++;
        end
      endcase
      if (!pf_q[0]) m_cnt = 0; else if (m_cnt < FILT) m_cnt++;
      void'(pf_q.pop_front()); pf_q.push_back(pfail);
      void'(sw_q.pop_front()); sw_q.push_back(swover);
    end
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit t, al;
    t  = m_trip();
    al = (m_st == 0) && !t;
    chk("R3 mem_ce_no", mem_ce_n, !(ce_req && al));
    chk("R3 mem_oe_no", mem_oe_n, !(ce_req && oe_req && al));
    chk("R2 mem_we_no", mem_we_n, !(ce_req && we_req && al));
    chk("R8 ready_o", ready, al);
    chk("R5 protected_o", prot, t || m_st == 1);
    chk("R9 abort_o", abort_p, (m_st == 0) && t && ce_req);
  endtask

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    ce_req = 1'b1; we_req = 1'b1; oe_req = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state with requests asserted
    chk("R1 ready", ready, 0);
    chk("R1 protected", prot, 1);
    chk("R1 ce_n", mem_ce_n, 1);
    chk("R1 we_n", mem_we_n, 1);
    chk("R1 oe_n", mem_oe_n, 1);

    // R6: power-up recovery length
    n = 0;
    while (!ready && n < 1000) begin tick(1); n++; end
    chk("R6 cycles to ready", n, REC_CYC + 1);

    // R8: pass-through in NORMAL, several patterns
    ce_req = 1'b1; we_req = 1'b1; oe_req = 1'b0; tick(1);
    chk("R8 write we_n", mem_we_n, 0);
    chk("R8 write oe_n", mem_oe_n, 1);
    ce_req = 1'b1; we_req = 1'b0; oe_req = 1'b1; tick(1);
    chk("R8 read oe_n", mem_oe_n, 0);
    chk("R8 read ce_n", mem_ce_n, 0);
    ce_req = 1'b0; we_req = 1'b1; oe_req = 1'b1; tick(1);
    chk("R8 idle ce_n", mem_ce_n, 1);
    chk("R8 idle we_n", mem_we_n, 1);

    // R4: glitch shorter than the filter
    pfail = 1'b1; tick(FILT - 1);
    pfail = 1'b0; tick(STAGES + FILT + 2);
    chk("R4 glitch protected", prot, 0);
    chk("R4 glitch ready", ready, 1);

    // R5, R9, R2: real fail during a write
    ce_req = 1'b1; we_req = 1'b1; oe_req = 1'b0;
    pfail = 1'b1;
    n = 0;
    while (!prot && n < 100) begin tick(1); n++; end
    chk("R5 latency", n, STAGES + FILT);
    chk("R9 abort pulse", abort_p, 1);
    chk("R2 we_n at trip", mem_we_n, 1);
    tick(1);
    chk("R9 abort single", abort_p, 0);
    oe_req = 1'b1; tick(3);
    chk("R2 write ignored", mem_we_n, 1);
    chk("R3 oe held off", mem_oe_n, 1);

    // R7: re-trip in the middle of recovery restarts timing
    pfail = 1'b0;
    n = 0;
    while (prot && n < 100) begin tick(1); n++; end
    chk("R6 recovering ready low", ready, 0);
    tick(REC_CYC / 2);
    pfail = 1'b1; tick(STAGES + FILT + 2);
    chk("R7 back to protected", prot, 1);
    pfail = 1'b0;
    n = 0;
    while (prot && n < 100) begin tick(1); n++; end
    n = 0;
    while (!ready && n < 1000) begin tick(1); n++; end
    chk("R7 full recovery", n, REC_CYC);

    // R10: switchover bypasses the filter; no abort without an access
    ce_req = 1'b0; we_req = 1'b0;
    swover = 1'b1;
    n = 0;
    while (!prot && n < 100) begin tick(1); n++; end
    chk("R10 switchover latency", n, STAGES);
    chk("R9 no abort when idle", abort_p, 0);
    swover = 1'b0;
    n = 0;
    while (!ready && n < 1000) begin tick(1); n++; end
    chk("R6 ready after switchover", ready, 1);
    tick(2);
    finish_run();
  end
endmodule